// File: doc/BRIEF.md
# Registered Bidirectional Pad Cell

This block is one configurable bidirectional pad slice, `WIDTH` bits wide, that sits between the core logic and a tri-state pad. It holds three banks of flops: a capture register on the inbound path, a data register on the outbound path and an enable register for the tri-state control. Each bank has its own clock enable. All three banks share one clock and one asynchronous reset.

Two static select inputs decide whether the pad data and the tri-state control come straight from the core or from their registers. A two-bit drive-style input picks how the chosen data reaches the pad: true polarity, inverted polarity, or an inverting open-drain pull-down. Toward the core, the cell returns the live pad value and the captured pad value side by side. It also returns the contents of the outbound data register. Because of that feedback, the data register stays useful as a plain core flop when the pad is never enabled.

Top module: `bidir_pad_cell`

## Requirements
- R1: While `rst_n` is low, all three registers read 0 at once, without waiting for a clock edge. `core_din_reg` and `core_dout_fb` are 0, and a pad whose enable comes from the enable register is released (high impedance).
- R2: `core_din_comb` follows the pad combinationally. `core_din_reg` takes the pad value on a rising clock edge when `din_ce` is 1.
- R3: Each register loads on a rising edge only when its own clock enable (`din_ce`, `dout_ce`, `oe_ce`) is 1. Otherwise it holds its value, whatever its data input does.
- R4: `cfg_dout_reg` = 0 sends `core_dout` to the pad driver. `cfg_dout_reg` = 1 sends the outbound data register instead.
- R5: `cfg_oe_reg` = 0 takes the tri-state enable from `core_oe`. `cfg_oe_reg` = 1 takes it from the enable register. A 1 means enabled.
- R6: `cfg_drive` = 2'b00 (true polarity): an enabled pad bit carries the selected data bit. The code 2'b11 behaves the same way.
- R7: `cfg_drive` = 2'b01 (inverted polarity): an enabled pad bit carries the inverse of the selected data bit.
- R8: `cfg_drive` = 2'b10 (open-drain inverting): an enabled bit is driven to 0 when its data is 1 and released when its data is 0. The cell never drives a 1 in this mode.
- R9: A pad bit whose selected enable is 0 is released in every drive style, for any data value.
- R10: `core_dout_fb` always shows the outbound data register. It keeps loading and reporting data while the pad stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all three registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to `clk` |
| cfg_dout_reg | input | 1 | 1 selects the registered pad data, 0 the combinational data |
| cfg_oe_reg | input | 1 | 1 selects the registered enable, 0 the combinational enable |
| cfg_drive | input | 2 | Drive style: 00 true, 01 inverted, 10 open-drain inverting, 11 as 00 |
| core_dout | input | WIDTH | Outbound data from the core |
| core_oe | input | WIDTH | Per-bit tri-state enable from the core, 1 drives |
| dout_ce | input | 1 | Clock enable of the outbound data register |
| oe_ce | input | 1 | Clock enable of the enable register |
| din_ce | input | 1 | Clock enable of the inbound capture register |
| pad | inout | WIDTH | Tri-state pad bits |
| core_din_comb | output | WIDTH | Live pad value toward the core |
| core_din_reg | output | WIDTH | Captured pad value toward the core |
| core_dout_fb | output | WIDTH | Contents of the outbound data register |

## Verification
The bench puts a pull-up on every pad bit, so a released bit reads 1. Each stimulus is therefore chosen so that the driven level is 0 wherever release has to be told apart from driving. That exposes an open-drain mode that drives 1s, an enable that ignores its select, and a polarity swap between the true and inverted styles.

The directed part runs several checks:
- Registers are loaded and their clock enables then dropped. A design that shares one enable across the three banks changes the pad or the feedback.
- The registered enable is cleared while the data register keeps loading. A cell that ties the feedback to pad activity would stop updating `core_dout_fb`.
- Reset is pulled mid-run, and the outputs are read at once to catch a reset that waits for a clock.

// File: rtl/bidir_pad_pkg.sv
package bidir_pad_pkg;

  typedef enum logic [1:0] {
    DRV_TRUE  = 2'b00,
    DRV_INV   = 2'b01,
    DRV_ODINV = 2'b10,
    DRV_ALT   = 2'b11
  } drive_style_e;

endpackage

// File: rtl/bpc_ce_reg.sv
module bpc_ce_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ce) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R3: load only with the enable, otherwise hold
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (q == $past(d)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(q));

  // R1: cleared while reset is held
  always @(negedge clk) begin
    if (!rst_n) p_clear_r1: assert (q == '0);
  end

endmodule

// File: rtl/bpc_src_sel.sv
module bpc_src_sel #(
  parameter int W = 4
) (
  input  logic         use_reg,
  input  logic [W-1:0] comb_src,
  input  logic [W-1:0] reg_src,
  output logic [W-1:0] y
);

  always_comb begin
    y = use_reg ? reg_src : comb_src;
  end

endmodule

// File: rtl/bpc_pad_drive.sv
module bpc_pad_drive
  import bidir_pad_pkg::*;
#(
  parameter int W = 4
) (
  input  drive_style_e style,
  input  logic [W-1:0] data,
  input  logic [W-1:0] en,
  output logic [W-1:0] drv_val,
  output logic [W-1:0] drv_en
);

  always_comb begin
    unique case (style)
      DRV_INV: begin
        drv_val = ~data;
        drv_en  = en;
      end
      DRV_ODINV: begin
        drv_val = '0;
        drv_en  = en & data;
      end
      default: begin
        drv_val = data;
        drv_en  = en;
      end
    endcase
  end

endmodule

// File: rtl/bidir_pad_cell.sv
module bidir_pad_cell
  import bidir_pad_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dout_reg,
  input  logic             cfg_oe_reg,
  input  logic [1:0]       cfg_drive,
  input  logic [WIDTH-1:0] core_dout,
  input  logic [WIDTH-1:0] core_oe,
  input  logic             dout_ce,
  input  logic             oe_ce,
  input  logic             din_ce,
  inout  wire  [WIDTH-1:0] pad,
  output logic [WIDTH-1:0] core_din_comb,
  output logic [WIDTH-1:0] core_din_reg,
  output logic [WIDTH-1:0] core_dout_fb
);

  localparam int LAST = WIDTH - 1;

  drive_style_e   style;
  logic [LAST:0]  dout_q, oe_q, din_q;
  logic [LAST:0]  data_sel, en_sel;
  logic [LAST:0]  drv_val, drv_en;
  logic [LAST:0]  pad_in;

  assign style = drive_style_e'(cfg_drive);

  bpc_ce_reg #(.W(WIDTH)) u_dout_reg (
    .clk(clk), .rst_n(rst_n), .ce(dout_ce), .d(core_dout), .q(dout_q));
  bpc_ce_reg #(.W(WIDTH)) u_oe_reg (
    .clk(clk), .rst_n(rst_n), .ce(oe_ce), .d(core_oe), .q(oe_q));
  bpc_ce_reg #(.W(WIDTH)) u_din_reg (
    .clk(clk), .rst_n(rst_n), .ce(din_ce), .d(pad_in), .q(din_q));

  bpc_src_sel #(.W(WIDTH)) u_data_sel (
    .use_reg(cfg_dout_reg), .comb_src(core_dout), .reg_src(dout_q), .y(data_sel));
  bpc_src_sel #(.W(WIDTH)) u_en_sel (
    .use_reg(cfg_oe_reg), .comb_src(core_oe), .reg_src(oe_q), .y(en_sel));

  bpc_pad_drive #(.W(WIDTH)) u_drive (
    .style(style), .data(data_sel), .en(en_sel),
    .drv_val(drv_val), .drv_en(drv_en));

  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    assign pad[i]    = drv_en[i] ? drv_val[i] : 1'bz;
    assign pad_in[i] = pad[i];
  end

  assign core_din_comb = pad_in;
  assign core_din_reg  = din_q;
  assign core_dout_fb  = dout_q;

  // R9: a cleared enable register releases every bit when selected
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_oe_reg |-> ((drv_en & ~oe_q) == '0));
  // R8: open-drain never drives a one
  p_od_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (style == DRV_ODINV) |-> ((drv_en & drv_val) == '0));
  // R4: registered true-polarity drive follows the data register
  p_regpath_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dout_reg && style == DRV_TRUE) |-> ((drv_en & (drv_val ^ dout_q)) == '0));
  // R7: inverted style drives the complement of the data register
  p_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dout_reg && style == DRV_INV) |-> ((drv_en & (drv_val ^ ~dout_q)) == '0));

endmodule

// File: tb/tb_bidir_pad_cell.sv
module tb_bidir_pad_cell;

  localparam int W = 4;

  logic         clk;
  logic         rst_n;
  logic         cfg_dout_reg, cfg_oe_reg;
  logic [1:0]   cfg_drive;
  logic [W-1:0] core_dout, core_oe;
  logic         dout_ce, oe_ce, din_ce;
  logic [W-1:0] tb_val, tb_en;
  tri1  [W-1:0] pad_w;
  logic [W-1:0] core_din_comb, core_din_reg, core_dout_fb;

  int checks   = 0;
  int failures = 0;

  for (genvar i = 0; i < W; i++) begin : g_tbdrv
    assign pad_w[i] = tb_en[i] ? tb_val[i] : 1'bz;
  end

  bidir_pad_cell #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_dout_reg(cfg_dout_reg), .cfg_oe_reg(cfg_oe_reg), .cfg_drive(cfg_drive),
    .core_dout(core_dout), .core_oe(core_oe),
    .dout_ce(dout_ce), .oe_ce(oe_ce), .din_ce(din_ce),
    .pad(pad_w),
    .core_din_comb(core_din_comb), .core_din_reg(core_din_reg),
    .core_dout_fb(core_dout_fb));

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // {drive style, enable, data, expected pad with pull-up}
  localparam logic [13:0] VEC [8] = '{
    {2'b00, 4'hF, 4'hA, 4'hA},
    {2'b00, 4'h0, 4'h0, 4'hF},
    {2'b01, 4'hF, 4'hA, 4'h5},
    {2'b01, 4'h3, 4'hF, 4'hC},
    {2'b10, 4'hF, 4'hA, 4'h5},
    {2'b10, 4'h5, 4'hF, 4'hA},
    {2'b11, 4'hF, 4'h6, 4'h6},
    {2'b00, 4'h9, 4'h0, 4'h6}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    cfg_dout_reg = 1'b0; cfg_oe_reg = 1'b1; cfg_drive = 2'b00;
    core_dout = '0; core_oe = '0;
    dout_ce = 1'b0; oe_ce = 1'b0; din_ce = 1'b0;
    tb_val = '0; tb_en = '0;
    #1 rst_n = 1'b0;
    tick(); tick();
    chk("R1 feedback in reset", core_dout_fb, 4'h0);
    chk("R1 capture in reset", core_din_reg, 4'h0);
    chk("R1 pad released in reset", pad_w, 4'hF);
    rst_n = 1'b1;
    tick();

    // table walk: combinational data and enable
    cfg_oe_reg = 1'b0;
    for (int k = 0; k < 8; k++) begin
      cfg_drive = VEC[k][13:12];
      core_oe   = VEC[k][11:8];
      core_dout = VEC[k][7:4];
      #1;
      chk("R6 R7 R8 R9 pad by drive style", pad_w, VEC[k][3:0]);
      chk("R2 live pad to core", core_din_comb, VEC[k][3:0]);
      #2;
    end

    // registered data and enable
    cfg_drive = 2'b00; cfg_dout_reg = 1'b1; cfg_oe_reg = 1'b1;
    core_dout = 4'h3; core_oe = 4'hF; dout_ce = 1'b1; oe_ce = 1'b1;
    tick();
    chk("R4 R5 registered drive", pad_w, 4'h3);
    chk("R10 feedback loaded", core_dout_fb, 4'h3);

    // hold with enables low
    dout_ce = 1'b0; oe_ce = 1'b0; core_dout = 4'hC; core_oe = 4'h0;
    tick();
    chk("R3 data and enable held", pad_w, 4'h3);
    chk("R3 feedback held", core_dout_fb, 4'h3);

    // combinational data select while register holds 3
    cfg_dout_reg = 1'b0;
    #1;
    chk("R4 combinational data select", pad_w, 4'hC);

    // inverted polarity from the register
    cfg_dout_reg = 1'b1; cfg_drive = 2'b01;
    #1;
    chk("R7 inverted registered", pad_w, 4'hC);
    cfg_drive = 2'b00;

    // clear enable register, keep loading data
    oe_ce = 1'b1;
    tick();
    oe_ce = 1'b0;
    chk("R5 R9 enable register cleared", pad_w, 4'hF);
    dout_ce = 1'b1; core_dout = 4'h5;
    tick();
    dout_ce = 1'b0;
    chk("R10 feedback while released", core_dout_fb, 4'h5);
    chk("R9 pad still released", pad_w, 4'hF);

    // capture path
    tb_val = 4'h9; tb_en = 4'hF; din_ce = 1'b1;
    tick();
    chk("R2 capture pad", core_din_reg, 4'h9);
    din_ce = 1'b0; tb_val = 4'h6;
    tick();
    chk("R3 capture held", core_din_reg, 4'h9);
    chk("R2 live pad", core_din_comb, 4'h6);

    // asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async clear feedback", core_dout_fb, 4'h0);
    chk("R1 async clear capture", core_din_reg, 4'h0);
    tb_en = '0;
    tick();
    rst_n = 1'b1;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule